// File: doc/BRIEF.md
# Instruction Control Decoder

This block turns a 32-bit instruction word into the control levels that steer a single-cycle datapath. It has no state: the outputs follow the instruction within the same cycle. A main decoder reads the opcode and picks a group of datapath actions: register write-back, memory read or write, immediate operand, branch and jump. It also picks a 2-bit ALU category. A separate ALU-control stage then resolves that category into a concrete ALU operation. For register-register instructions it does this by inspecting the funct3 and funct7 fields.

The supported set is register add and subtract, word load, word store, branch-if-equal and jump-and-link. Any other opcode, or a supported opcode whose funct fields select something this block does not implement, is reported on a single illegal-instruction output. In that case every state-changing enable is held low, so the surrounding datapath cannot modify registers, memory or the program counter flow.

Top module: `ctrl_decoder`

## Requirements
- R1: Opcode 0110011 with funct3 000 (bits 14:12) and funct7 0000000 (bits 31:25) gives reg_we=1, alu_imm=0, wb_from_mem=0, alu_cat=10, alu_op=0000 (add), with every other enable low and illegal=0.
- R2: Opcode 0110011 with funct3 000 and funct7 0100000 gives the same controls as R1 but alu_op=0001 (subtract).
- R3: Opcode 0000011 with funct3 010 gives alu_imm=1, mem_rd=1, wb_from_mem=1, reg_we=1, alu_cat=00, alu_op=0000, all else low.
- R4: Opcode 0100011 with funct3 010 gives alu_imm=1, mem_wr=1, reg_we=0, alu_cat=00, alu_op=0000, all else low.
- R5: Opcode 1100011 with funct3 000 gives branch=1, alu_imm=0, alu_cat=01, alu_op=0001, with no register or memory enable.
- R6: Opcode 1101111 gives jump=1 and reg_we=1 with alu_cat=00, alu_op=0000, all else low, whatever the funct fields hold.
- R7: Any opcode (bits 6:0) other than the five above raises illegal and drives every control output low, with alu_cat=00 and alu_op=0000.
- R8: A supported opcode whose funct fields are not listed in R1 to R5 is handled exactly as in R7.
- R9: The register and immediate fields (bits 24:15 and 11:7) never change any output.
- R10: mem_rd and mem_wr are never high together, branch and jump are never high together, and wb_from_mem is only high with mem_rd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word to decode |
| reg_we_o | output | 1 | Register file write enable |
| mem_rd_o | output | 1 | Data memory read enable |
| mem_wr_o | output | 1 | Data memory write enable |
| wb_from_mem_o | output | 1 | Write-back source: 1 selects memory data, 0 the ALU result |
| alu_imm_o | output | 1 | Second ALU operand: 1 selects the immediate, 0 the second register |
| branch_o | output | 1 | Conditional branch decision requested |
| jump_o | output | 1 | Unconditional jump target selected |
| alu_cat_o | output | 2 | ALU category: 00 address add, 01 compare subtract, 10 funct-driven |
| alu_op_o | output | 4 | Resolved ALU operation: 0000 add, 0001 subtract |
| illegal_o | output | 1 | Instruction not supported |

## Verification
The bench builds the decoder with its default 32-bit instruction width and 4-bit ALU operation code. At that width the whole opcode space is small enough to sweep, so every one of the 128 opcodes is applied, each with randomised funct and operand fields. This reaches the unknown-opcode path and the funct-mismatch path on every supported opcode. Pairs of words that differ only in operand bits show that those fields have no effect.

// File: rtl/ctrl_dec_pkg.sv
package ctrl_dec_pkg;

  localparam int unsigned OPC_W    = 7;
  localparam int unsigned F3_W     = 3;
  localparam int unsigned F7_W     = 7;
  localparam int unsigned ALU_OP_W = 4;
  localparam int unsigned CAT_W    = 2;

  localparam logic [OPC_W-1:0] OPC_REG    = 7'b0110011;
  localparam logic [OPC_W-1:0] OPC_LOAD   = 7'b0000011;
  localparam logic [OPC_W-1:0] OPC_STORE  = 7'b0100011;
  localparam logic [OPC_W-1:0] OPC_BRANCH = 7'b1100011;
  localparam logic [OPC_W-1:0] OPC_JAL    = 7'b1101111;

  localparam logic [F3_W-1:0] F3_ADDSUB = 3'b000;
  localparam logic [F3_W-1:0] F3_WORD   = 3'b010;
  localparam logic [F3_W-1:0] F3_EQ     = 3'b000;
  localparam logic [F7_W-1:0] F7_BASE   = 7'b0000000;
  localparam logic [F7_W-1:0] F7_ALT    = 7'b0100000;

  typedef enum logic [CAT_W-1:0] {
    CAT_ADDR  = 2'b00,
    CAT_CMP   = 2'b01,
    CAT_FUNCT = 2'b10,
    CAT_RSVD  = 2'b11
  } alu_cat_e;

  typedef enum logic [ALU_OP_W-1:0] {
    ALU_ADD = 4'b0000,
    ALU_SUB = 4'b0001
  } alu_op_e;

  typedef struct packed {
    logic     reg_we;
    logic     mem_rd;
    logic     mem_wr;
    logic     wb_from_mem;
    logic     alu_imm;
    logic     branch;
    logic     jump;
    alu_cat_e cat;
  } ctrl_t;

  localparam ctrl_t CTRL_IDLE = '{reg_we: 1'b0, mem_rd: 1'b0, mem_wr: 1'b0,
                                  wb_from_mem: 1'b0, alu_imm: 1'b0,
                                  branch: 1'b0, jump: 1'b0, cat: CAT_ADDR};

  // Register-register funct resolution: result is {unsupported, op}.
  function automatic logic [ALU_OP_W:0] resolve_funct(
    input logic [F3_W-1:0] f3,
    input logic [F7_W-1:0] f7
  );
    logic [ALU_OP_W:0] r;
    r = {1'b1, ALU_ADD};
    if (f3 == F3_ADDSUB) begin
      if (f7 == F7_BASE)     r = {1'b0, ALU_ADD};
      else if (f7 == F7_ALT) r = {1'b0, ALU_SUB};
    end
    return r;
  endfunction

  // funct3 qualifier for opcodes that are not register-register.
  function automatic logic f3_ok(
    input logic [OPC_W-1:0] opc,
    input logic [F3_W-1:0]  f3
  );
    logic ok;
    case (opc)
      OPC_LOAD, OPC_STORE: ok = (f3 == F3_WORD);
      OPC_BRANCH:          ok = (f3 == F3_EQ);
      default:             ok = 1'b1;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/ctrl_field_split.sv
module ctrl_field_split
  import ctrl_dec_pkg::*;
#(
  parameter int unsigned ILEN = 32
) (
  input  logic [ILEN-1:0]  instr_i,
  output logic [OPC_W-1:0] opcode_o,
  output logic [F3_W-1:0]  funct3_o,
  output logic [F7_W-1:0]  funct7_o
);
  localparam int unsigned F3_LSB = OPC_W + 5;
  localparam int unsigned F7_LSB = ILEN - F7_W;

  assign opcode_o = instr_i[OPC_W-1:0];
  assign funct3_o = instr_i[F3_LSB +: F3_W];
  assign funct7_o = instr_i[F7_LSB +: F7_W];

  // Operand fields carry no control meaning here.
  logic unused_operand_bits;
  assign unused_operand_bits = ^{instr_i[F7_LSB-1:F3_LSB+F3_W],
                                 instr_i[F3_LSB-1:OPC_W]};
endmodule

// File: rtl/ctrl_main_dec.sv
module ctrl_main_dec
  import ctrl_dec_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  input  logic [F3_W-1:0]  funct3_i,
  output ctrl_t            ctrl_o,
  output logic             opc_bad_o
);
  ctrl_t c;
  logic  bad;
  logic  qual_ok;

  assign qual_ok = f3_ok(opcode_i, funct3_i);

  always_comb begin
    c   = CTRL_IDLE;
    bad = 1'b0;
    case (opcode_i)
      OPC_REG: begin
        c.reg_we = 1'b1;
        c.cat    = CAT_FUNCT;
      end
      OPC_LOAD: begin
        c.alu_imm     = 1'b1;
        c.mem_rd      = 1'b1;
        c.wb_from_mem = 1'b1;
        c.reg_we      = 1'b1;
      end
      OPC_STORE: begin
        c.alu_imm = 1'b1;
        c.mem_wr  = 1'b1;
      end
      OPC_BRANCH: begin
        c.branch = 1'b1;
        c.cat    = CAT_CMP;
      end
      OPC_JAL: begin
        c.jump   = 1'b1;
        c.reg_we = 1'b1;
      end
      default: bad = 1'b1;
    endcase
    if (!qual_ok) begin
      c   = CTRL_IDLE;
      bad = 1'b1;
    end

    AST_ONE_MEM_PORT: assert (!(c.mem_rd && c.mem_wr)) else $error("mem read and write together"); // R10
    AST_WB_NEEDS_READ: assert (!c.wb_from_mem || c.mem_rd) else $error("memory write-back without read"); // R10
    AST_BR_JMP_EXCL: assert (!(c.branch && c.jump)) else $error("branch and jump together"); // R10
    AST_STORE_NO_WB: assert (!c.mem_wr || !c.reg_we) else $error("store writes register"); // R4
  end

  assign ctrl_o    = c;
  assign opc_bad_o = bad;
endmodule

// File: rtl/ctrl_alu_dec.sv
module ctrl_alu_dec
  import ctrl_dec_pkg::*;
(
  input  alu_cat_e        cat_i,
  input  logic [F3_W-1:0] funct3_i,
  input  logic [F7_W-1:0] funct7_i,
  output alu_op_e         alu_op_o,
  output logic            funct_bad_o
);
  logic [ALU_OP_W:0] rr;
  alu_op_e           op;
  logic              bad;

  assign rr = resolve_funct(funct3_i, funct7_i);

  always_comb begin
    op  = ALU_ADD;
    bad = 1'b0;
    case (cat_i)
      CAT_ADDR:  op = ALU_ADD;
      CAT_CMP:   op = ALU_SUB;
      CAT_FUNCT: begin
        op  = alu_op_e'(rr[ALU_OP_W-1:0]);
        bad = rr[ALU_OP_W];
      end
      default:   bad = 1'b1;
    endcase

    AST_CMP_IS_SUB: assert (cat_i != CAT_CMP || op == ALU_SUB) else $error("compare category not subtract"); // R5
    AST_FUNCT_ONLY_RR: assert (!bad || cat_i != CAT_ADDR) else $error("funct fault outside funct category"); // R8
  end

  assign alu_op_o    = op;
  assign funct_bad_o = bad;
endmodule

// File: rtl/ctrl_decoder.sv
module ctrl_decoder
  import ctrl_dec_pkg::*;
#(
  parameter int unsigned ILEN = 32
) (
  input  logic [ILEN-1:0]     instr_i,
  output logic                reg_we_o,
  output logic                mem_rd_o,
  output logic                mem_wr_o,
  output logic                wb_from_mem_o,
  output logic                alu_imm_o,
  output logic                branch_o,
  output logic                jump_o,
  output logic [CAT_W-1:0]    alu_cat_o,
  output logic [ALU_OP_W-1:0] alu_op_o,
  output logic                illegal_o
);
  logic [OPC_W-1:0] opcode;
  logic [F3_W-1:0]  funct3;
  logic [F7_W-1:0]  funct7;
  ctrl_t            raw_ctrl;
  logic             opc_bad;
  alu_op_e          raw_op;
  logic             funct_bad;
  logic             illegal;
  ctrl_t            fin_ctrl;
  alu_op_e          fin_op;

  ctrl_field_split #(.ILEN(ILEN)) u_split (
    .instr_i (instr_i),
    .opcode_o(opcode),
    .funct3_o(funct3),
    .funct7_o(funct7)
  );

  ctrl_main_dec u_main (
    .opcode_i (opcode),
    .funct3_i (funct3),
    .ctrl_o   (raw_ctrl),
    .opc_bad_o(opc_bad)
  );

  ctrl_alu_dec u_alu (
    .cat_i      (raw_ctrl.cat),
    .funct3_i   (funct3),
    .funct7_i   (funct7),
    .alu_op_o   (raw_op),
    .funct_bad_o(funct_bad)
  );

  assign illegal  = opc_bad | funct_bad;
  assign fin_ctrl = illegal ? CTRL_IDLE : raw_ctrl;
  assign fin_op   = illegal ? ALU_ADD : raw_op;

  assign reg_we_o      = fin_ctrl.reg_we;
  assign mem_rd_o      = fin_ctrl.mem_rd;
  assign mem_wr_o      = fin_ctrl.mem_wr;
  assign wb_from_mem_o = fin_ctrl.wb_from_mem;
  assign alu_imm_o     = fin_ctrl.alu_imm;
  assign branch_o      = fin_ctrl.branch;
  assign jump_o        = fin_ctrl.jump;
  assign alu_cat_o     = fin_ctrl.cat;
  assign alu_op_o      = fin_op;
  assign illegal_o     = illegal;

  always_comb begin
    AST_ILLEGAL_QUIET: assert (!(opc_bad || funct_bad) ||
                              !(reg_we_o || mem_rd_o || mem_wr_o || branch_o || jump_o))
      else $error("enable raised on illegal instruction"); // R7
    AST_FUNCT_FAULT_FLAGGED: assert (!funct_bad || illegal_o) else $error("funct fault not flagged"); // R8
  end
endmodule

// File: tb/ctrl_decoder_tb.sv
module ctrl_decoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr = 32'd0;
  logic        reg_we, mem_rd, mem_wr, wb_mem, alu_imm, branch, jump, illegal;
  logic [1:0]  alu_cat;
  logic [3:0]  alu_op;

  int unsigned checks = 0;
  int unsigned errors = 0;
  bit          done = 1'b0;

  logic [13:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ctrl_decoder u_dut (
    .instr_i      (instr),
    .reg_we_o     (reg_we),
    .mem_rd_o     (mem_rd),
    .mem_wr_o     (mem_wr),
    .wb_from_mem_o(wb_mem),
    .alu_imm_o    (alu_imm),
    .branch_o     (branch),
    .jump_o       (jump),
    .alu_cat_o    (alu_cat),
    .alu_op_o     (alu_op),
    .illegal_o    (illegal)
  );

  // {illegal, reg_we, mem_rd, mem_wr, wb, imm, branch, jump, cat[1:0], op[3:0]}
  function automatic logic [13:0] model(input logic [31:0] w);
    logic [6:0] opc = w[6:0];
    logic [2:0] f3  = w[14:12];
    logic [6:0] f7  = w[31:25];
    logic [13:0] bad = {1'b1, 13'd0};
    case (opc)
      7'h33: begin
        if (f3 == 3'd0 && f7 == 7'h00)      return {8'b0100_0000, 2'b10, 4'd0};
        else if (f3 == 3'd0 && f7 == 7'h20) return {8'b0100_0000, 2'b10, 4'd1};
        else return bad;
      end
      7'h03: return (f3 == 3'd2) ? {8'b0110_1100, 2'b00, 4'd0} : bad;
      7'h23: return (f3 == 3'd2) ? {8'b0001_0100, 2'b00, 4'd0} : bad;
      7'h63: return (f3 == 3'd0) ? {8'b0000_0010, 2'b01, 4'd1} : bad;
      7'h6F: return {8'b0100_0001, 2'b00, 4'd0};
      default: return bad;
    endcase
  endfunction

  task automatic drive(input logic [31:0] w, input string tag);
    @(posedge clk);
    #1;
    instr = w;
    exp_q.push_back(model(w));
    tag_q.push_back(tag);
  endtask

  task automatic drive_exp(input logic [31:0] w, input logic [13:0] e, input string tag);
    @(posedge clk);
    #1;
    instr = w;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (rst_n && exp_q.size() > 0) begin
      logic [13:0] e;
      logic [13:0] a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {illegal, reg_we, mem_rd, mem_wr, wb_mem, alu_imm, branch, jump, alu_cat, alu_op};
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s instr=%h actual=%b expected=%b", t, instr, a, e);
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // Reset state: all-zero word is an unknown opcode (R7).
    drive_exp(32'd0, {1'b1, 13'd0}, "R7 reset word");
    // Hand-written expectations straight from the requirement text.
    drive_exp({7'h00, 5'd7, 5'd6, 3'd0, 5'd5, 7'h33}, 14'b0_1000_000_10_0000, "R1 add");
    drive_exp({7'h20, 5'd7, 5'd6, 3'd0, 5'd5, 7'h33}, 14'b0_1000_000_10_0001, "R2 sub");
    drive_exp({12'd12, 5'd9, 3'd2, 5'd8, 7'h03},      14'b0_1101_100_00_0000, "R3 load");
    drive_exp({7'h00, 5'd10, 5'd11, 3'd2, 5'd8, 7'h23}, 14'b0_0010_100_00_0000, "R4 store");
    drive_exp({7'h00, 5'd2, 5'd1, 3'd0, 5'd4, 7'h63}, 14'b0_0000_010_01_0001, "R5 beq");
    drive_exp({7'h55, 5'd3, 5'd3, 3'd5, 5'd3, 7'h6F}, 14'b0_1000_001_00_0000, "R6 jal");
    drive_exp({7'h01, 5'd7, 5'd6, 3'd0, 5'd5, 7'h33}, {1'b1, 13'd0}, "R8 bad funct7");
    drive_exp({7'h00, 5'd7, 5'd6, 3'd1, 5'd5, 7'h33}, {1'b1, 13'd0}, "R8 bad funct3 reg");
    drive_exp({12'd4, 5'd9, 3'd0, 5'd8, 7'h03},       {1'b1, 13'd0}, "R8 byte load");
    drive_exp({7'h00, 5'd10, 5'd11, 3'd1, 5'd8, 7'h23}, {1'b1, 13'd0}, "R8 half store");
    drive_exp({7'h00, 5'd2, 5'd1, 3'd1, 5'd4, 7'h63}, {1'b1, 13'd0}, "R8 bne");
    drive_exp(32'h0000_0013, {1'b1, 13'd0}, "R7 unknown opcode");
    // Sweep of every opcode with random funct and operand fields (R7, R8, R10).
    for (int op = 0; op < 128; op++) begin
      for (int k = 0; k < 3; k++) begin
        logic [31:0] w;
        w = $urandom;
        w[6:0] = op[6:0];
        if (k == 0) begin
          w[14:12] = (op == 7'h03 || op == 7'h23) ? 3'd2 : 3'd0;
          w[31:25] = 7'h00;
        end
        drive(w, "R7 R8 sweep");
      end
    end
    // Operand fields have no effect (R9).
    for (int k = 0; k < 40; k++) begin
      logic [31:0] base;
      logic [31:0] alt;
      case (k % 5)
        0: base = {7'h00, 10'd0, 3'd0, 5'd0, 7'h33};
        1: base = {7'h20, 10'd0, 3'd0, 5'd0, 7'h33};
        2: base = {7'h00, 10'd0, 3'd2, 5'd0, 7'h03};
        3: base = {7'h00, 10'd0, 3'd2, 5'd0, 7'h23};
        default: base = {7'h00, 10'd0, 3'd0, 5'd0, 7'h63};
      endcase
      alt = base;
      alt[24:15] = 10'($urandom);
      alt[11:7]  = 5'($urandom);
      drive_exp(alt, model(base), "R9 operand bits");
    end
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule